// File: doc/BRIEF.md
# Long-Interval Sequence Timer

This block measures very long intervals without a wide binary counter. A maximal-length linear feedback shift register of `N` bits advances on every enabled clock and steps through all 2^N - 1 nonzero states before it repeats. The serial bit leaving the top of the register feeds a small down counter that watches for zeros. A maximal sequence holds exactly one run of `N - 1` zeros per period. When that run ends, the down counter borrows, and the block raises a terminal-count pulse once per period.

With `N = 63` the period is 2^63 - 1 clocks, which is centuries at 100 MHz, yet the zero-run counter is only seven bits wide. The attainable intervals are fixed at 2^N - 1. For this reason an optional second stage counts terminal-count pulses modulo `UNIT_MOD`. It gives a coarser time unit with its own one-cycle tick. The shift register uses exclusive-OR feedback, and the feedback taps for each supported width are computed from a table in the package.

Top module: `lfsr_interval_timer`

## Requirements
- R1: While reset is asserted at a clock edge, the sequence state becomes the value 1 (only bit 0 set), the terminal-count output is low and the unit count is 0.
- R2: The sequence state is never all zeros. After every 2^N - 1 enabled cycles it returns to the value 1, and within one period it never takes the same value twice.
- R3: The terminal-count output is high in the window after exactly N - 1 enabled cycles have passed since reset, and again after every further 2^N - 1 enabled cycles. When it is high, the top bit of the sequence state is 1.
- R4: The terminal-count output is never high for two consecutive clock cycles.
- R5: While enable is low, the sequence state, the zero-run counter and the unit count hold their values, and terminal count stays low.
- R6: The unit count advances by one at each clock edge at which terminal count is high, wraps from UNIT_MOD - 1 to 0, and otherwise holds. It always stays below UNIT_MOD.
- R7: The unit tick is high exactly when terminal count is high and the unit count equals UNIT_MOD - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; when low, all state holds |
| tc_o | output | 1 | Terminal-count pulse, once per sequence period |
| state_o | output | N | Current shift register state |
| unit_count_o | output | UNIT_W | Count of terminal-count pulses modulo UNIT_MOD |
| unit_tick_o | output | 1 | One-cycle pulse when the unit count wraps |

## Verification
The assertions check the following on every cycle:
- the state never reaches the lockup value,
- terminal count is never two cycles wide and is silent while enable is low,
- the state and the unit count are frozen when they should be,
- terminal count only appears with the top state bit set,
- the unit tick only accompanies terminal count.

Only the bench scenarios can show timing that is counted over long spans: where the first pulse falls after reset, the exact spacing of 2^N - 1 enabled cycles under a gapped enable pattern, that every state in a period is visited once, and the modulo wrap of the unit counter.

// File: rtl/lfsr_timer_pkg.sv
package lfsr_timer_pkg;

   // Feedback tap mask for a maximal-length sequence of n bits.
   // Bit (t-1) is set for tap position t. Zero means unsupported width.
   function automatic logic [63:0] tap_mask(input int n);
      logic [63:0] m;
      m = '0;
      case (n)
         3:  begin m[2] = 1'b1; m[1] = 1'b1; end
         4:  begin m[3] = 1'b1; m[2] = 1'b1; end
         5:  begin m[4] = 1'b1; m[2] = 1'b1; end
         6:  begin m[5] = 1'b1; m[4] = 1'b1; end
         7:  begin m[6] = 1'b1; m[5] = 1'b1; end
         8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
         9:  begin m[8] = 1'b1; m[4] = 1'b1; end
         10: begin m[9] = 1'b1; m[6] = 1'b1; end
         11: begin m[10] = 1'b1; m[8] = 1'b1; end
         15: begin m[14] = 1'b1; m[13] = 1'b1; end
         16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
         17: begin m[16] = 1'b1; m[13] = 1'b1; end
         20: begin m[19] = 1'b1; m[16] = 1'b1; end
         22: begin m[21] = 1'b1; m[20] = 1'b1; end
         23: begin m[22] = 1'b1; m[17] = 1'b1; end
         25: begin m[24] = 1'b1; m[21] = 1'b1; end
         28: begin m[27] = 1'b1; m[24] = 1'b1; end
         31: begin m[30] = 1'b1; m[27] = 1'b1; end
         63: begin m[62] = 1'b1; m[61] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

   function automatic bit width_supported(input int n);
      return (tap_mask(n) != '0);
   endfunction

endpackage

// File: rtl/lfsr_seq_core.sv
module lfsr_seq_core
   import lfsr_timer_pkg::*;
#(
   parameter int N = 63
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         en_i,
   output logic [N-1:0] state_o,
   output logic         serial_o
);

   localparam logic [63:0]  TAPS_FULL = tap_mask(N);
   localparam logic [N-1:0] TAPS      = TAPS_FULL[N-1:0];
   localparam logic [N-1:0] SEED      = N'(1);

   logic [N-1:0] state_q;
   logic         fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= SEED;
      end else if (en_i) begin
         state_q <= {state_q[N-2:0], fb};
      end
   end

   assign state_o  = state_q;
   assign serial_o = state_q[N-1];

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
   parameter int N = 63
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic serial_i,
   output logic borrow_o
);

   // Magnitude bits to hold N-2, plus one borrow bit on top.
   localparam int          W      = $clog2(N) + 1;
   localparam logic [W-1:0] RELOAD = W'(N - 2);

   logic [W-1:0] run_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_q <= RELOAD;
      end else if (en_i) begin
         if (serial_i || run_q[W-1]) begin
            run_q <= RELOAD;
         end else begin
            run_q <= run_q - W'(1);
         end
      end
   end

   assign borrow_o = run_q[W-1];

endmodule

// File: rtl/unit_counter.sv
module unit_counter #(
   parameter int MOD = 60,
   parameter int CW  = 6
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          adv_i,
   output logic [CW-1:0] count_o,
   output logic          tick_o
);

   localparam logic [CW-1:0] LAST = CW'(MOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
   end

   assign count_o = cnt_q;
   assign tick_o  = adv_i && (cnt_q == LAST);

endmodule

// File: rtl/lfsr_interval_timer.sv
module lfsr_interval_timer
   import lfsr_timer_pkg::*;
#(
   parameter int N          = 63,
   parameter bit UNIT_STAGE = 1'b1,
   parameter int UNIT_MOD   = 60,
   parameter int UNIT_W     = $clog2(UNIT_MOD)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   output logic              tc_o,
   output logic [N-1:0]      state_o,
   output logic [UNIT_W-1:0] unit_count_o,
   output logic              unit_tick_o
);

   if (!width_supported(N)) begin : g_bad_width
      $error("lfsr_interval_timer: no tap set for this width");
   end
   if (UNIT_MOD < 2 || UNIT_W < 1 || UNIT_MOD > (1 << UNIT_W)) begin : g_bad_unit
      $error("lfsr_interval_timer: unit modulus does not fit its width");
   end

   logic serial;
   logic borrow;

   lfsr_seq_core #(.N(N)) i_core (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .state_o  (state_o),
      .serial_o (serial)
   );

   zero_run_detector #(.N(N)) i_zrun (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .serial_i (serial),
      .borrow_o (borrow)
   );

   assign tc_o = borrow && en_i;

   if (UNIT_STAGE) begin : g_unit
      unit_counter #(.MOD(UNIT_MOD), .CW(UNIT_W)) i_unit (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .adv_i   (tc_o),
         .count_o (unit_count_o),
         .tick_o  (unit_tick_o)
      );
   end else begin : g_no_unit
      assign unit_count_o = '0;
      assign unit_tick_o  = 1'b0;
   end

endmodule

// File: rtl/lfsr_interval_timer_chk.sv
module lfsr_interval_timer_chk #(
   parameter int N        = 63,
   parameter int UNIT_MOD = 60,
   parameter int UNIT_W   = 6
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              en_i,
   input logic              tc_o,
   input logic [N-1:0]      state_o,
   input logic [UNIT_W-1:0] unit_count_o,
   input logic              unit_tick_o
);

   // R2
   state_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o != '0);

   // R5
   state_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(state_o));

   // R5
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |-> !tc_o);

   // R4
   tc_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o |=> !tc_o);

   // R3
   tc_top_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      tc_o |-> state_o[N-1]);

   // R6
   unit_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      unit_count_o < UNIT_W'(UNIT_MOD - 1) || unit_count_o == UNIT_W'(UNIT_MOD - 1));

   // R6
   unit_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !tc_o |=> $stable(unit_count_o));

   // R7
   tick_needs_tc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      unit_tick_o |-> tc_o);

endmodule

bind lfsr_interval_timer lfsr_interval_timer_chk #(
   .N(N), .UNIT_MOD(UNIT_MOD), .UNIT_W(UNIT_W)
) i_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .en_i         (en_i),
   .tc_o         (tc_o),
   .state_o      (state_o),
   .unit_count_o (unit_count_o),
   .unit_tick_o  (unit_tick_o)
);

// File: tb/test_lfsr_interval_timer.sv
module test_lfsr_interval_timer;

   localparam int N   = 7;
   localparam int P   = (1 << N) - 1;
   localparam int MOD = 3;
   localparam int UW  = $clog2(MOD);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic          tc;
   logic [N-1:0]  state;
   logic [UW-1:0] ucnt;
   logic          utick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lfsr_interval_timer #(.N(N), .UNIT_STAGE(1'b1), .UNIT_MOD(MOD), .UNIT_W(UW)) i_lfsr_interval_timer (
      .clk_i(clk), .rst_i(rst), .en_i(en), .tc_o(tc), .state_o(state),
      .unit_count_o(ucnt), .unit_tick_o(utick)
   );

   typedef struct {
      bit adv;
      int m;
      bit tc;
      bit tick;
      int ucnt;
      bit at_seed;
   } item_t;

   item_t q[$];
   int    m_model = 0;
   int    u_model = 0;

   function automatic bit borrow_at(input int mm);
      return (mm >= N - 1) && (((mm - (N - 1)) % P) == 0);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: set enable for the next edge and push what that edge must produce.
   task automatic drive(input bit e);
      item_t it;
      @(negedge clk);
      en = e;
      if (e) begin
         if (borrow_at(m_model)) u_model = (u_model + 1) % MOD;
         m_model++;
      end
      it.adv     = e;
      it.m       = m_model;
      it.tc      = e && borrow_at(m_model);
      it.tick    = it.tc && (u_model == MOD - 1);
      it.ucnt    = u_model;
      it.at_seed = (m_model % P) == 0;
      q.push_back(it);
   endtask

   // Monitor: pop one expected item per edge and compare.
   bit           seen [0:(1<<N)-1];
   logic [N-1:0] prev_state;

   always @(posedge clk) begin
      item_t it;
      #1;
      if (q.size() != 0) begin
         it = q.pop_front();
         check(state != '0, "R2 nonzero state", int'(state), 1);
         check((state == N'(1)) == it.at_seed, "R2 seed return", int'(state), it.at_seed);
         if (it.adv && it.m < P) begin
            check(!seen[state], "R2 distinct state", int'(state), it.m);
            seen[state] = 1'b1;
         end
         if (!it.adv)
            check(state == prev_state, "R5 hold state", int'(state), int'(prev_state));
         if (it.tc)
            check(tc == 1'b1, "R3 tc position", tc, 1);
         else
            check(tc == 1'b0, "R4 tc quiet", tc, 0);
         check(int'(ucnt) == it.ucnt, "R6 unit count", int'(ucnt), it.ucnt);
         check(utick == it.tick, "R7 unit tick", utick, it.tick);
      end
      prev_state = state;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << N); i++) seen[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check(state == N'(1), "R1 reset state", int'(state), 1);
      check(tc == 1'b0, "R1 reset tc", tc, 0);
      check(ucnt == '0, "R1 reset unit count", int'(ucnt), 0);
      seen[1] = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      // steady enable over several periods
      for (int i = 0; i < 5 * P + 10; i++) drive(1'b1);
      // gapped enable pattern
      for (int i = 0; i < 700; i++) drive((i % 5) != 2 && (i % 11) != 7);
      // long pause, then resume
      for (int i = 0; i < 12; i++) drive(1'b0);
      for (int i = 0; i < 300; i++) drive(1'b1);
      drive(1'b0);
      while (q.size() != 0) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule